// File: doc/BRIEF.md
# Equal-Precision Reciprocal Frequency Counter

This block measures the frequency of a conditioned input signal with a relative accuracy that does not depend on where that frequency lies in the band. It contains two enable-controlled counters. One counts cycles of a fixed reference clock and the other counts rising edges of the measured signal. A gate request arrives from an external controller, which picks the gate width. Typical widths run from 0.1 s to 10 s, with short gates for high frequencies and long gates for low ones. Before the gate reaches either counter, a flip-flop clocked by the measured signal re-times it. Counting therefore opens and closes on edges of the measured signal and always spans a whole number of its periods.

At the end of a gate the controller reads the two captured counts. It computes the frequency as the reference frequency times the signal count divided by the reference count. The division, input shaping and display lie outside the block. A busy level marks a measurement in progress and a single-cycle done pulse marks fresh results. If either counter runs out of range, a sticky overflow flag is raised.

Top module: `freq_recip_counter`

## Requirements
- R1: While `rst` is high and after it falls, `busy`, `done` and `overflow` are 0 and both count outputs are 0. `rst` is synchronous and is seen on reference clock edges and on measured-signal edges.
- R2: `gate_req` is registered once in the reference domain. `busy` is high by the second `clk_ref` rising edge after `gate_req` is first sampled high, and it stays high while the synchronised count enable is active.
- R3: The reference counter's enable is the signal-domain enable passed through a two-flop synchroniser. For a measured signal with a period of exactly P reference cycles, the result satisfies `ref_count == sig_count * P` with `sig_count > 0`. Counting covers whole periods only.
- R4: `sig_count` equals the number of measured-signal periods in the gate, within two of gate width divided by P.
- R5: Results are published with a `done` pulse exactly one `clk_ref` cycle long. `busy` is low in that cycle and afterwards.
- R6: The counts and overflow flag remain unchanged on the outputs from one `done` pulse to the next.
- R7: A counter that would step past all ones stays at all ones (2^CNT_W - 1) and sets `overflow`. This applies to the reference counter and to the signal counter independently.
- R8: `overflow` is cleared by the next measurement. A measurement without overflow reports 0.
- R9: A rising gate request clears both counters, so a result never includes counts from an earlier measurement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock (nominally 100 MHz) |
| rst | input | 1 | Synchronous active-high reset |
| sig_in | input | 1 | Conditioned measured signal, used as a clock |
| gate_req | input | 1 | Gate request from the controller, in the reference domain |
| busy | output | 1 | Measurement in progress |
| done | output | 1 | One-cycle pulse when new results are valid |
| sig_count | output | CNT_W | Captured number of measured-signal periods |
| ref_count | output | CNT_W | Captured number of reference cycles over the same gate |
| overflow | output | 1 | Either counter saturated during the last measurement |

## Verification
The hardest case to reach is the one that proves the counters cover whole periods. The reference count must be an exact multiple of the signal count, and that only shows when the phase of the measured signal against the reference clock is fixed and known. The bench generates the measured signal with half-periods that are multiples of half a reference period, offset by a fixed fraction. Its edges therefore never coincide with reference edges, the synchroniser latency is the same at gate open and gate close, and `ref_count` must equal `sig_count` times the period exactly. Saturation of each counter separately is reached by building the design with a narrow counter and applying gates long enough to exhaust one counter but not the other.

// File: rtl/frq_pkg.sv
package frq_pkg;

    // Flops in the signal-to-reference enable synchroniser.
    localparam int SYNC_DEPTH = 2;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_MEAS = 1'b1
    } phase_e;

    // Rising-edge detect from a level and its registered copy.
    function automatic logic edge_up(input logic now_v, input logic prev_v);
        return now_v & ~prev_v;
    endfunction

endpackage

// File: rtl/frq_bit_sync.sv
module frq_bit_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b0;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q = chain[LAST];
endmodule

// File: rtl/frq_sat_counter.sv
module frq_sat_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         en,
    output logic [W-1:0] cnt,
    output logic         ovf
);
    localparam logic [W-1:0] ALL_ONES = '1;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
            ovf <= 1'b0;
        end else if (en) begin
            if (cnt == ALL_ONES) ovf <= 1'b1;
            else                 cnt <= cnt + 1'b1;
        end
    end

    // R7: a full counter stays full and flags the overflow
    p_sat_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (cnt == ALL_ONES && en && !clr) |=> (cnt == ALL_ONES && ovf));

    // R9: clearing empties the count and the flag
    p_clear_r9: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt == '0 && !ovf));

    // R3: each enabled cycle below the ceiling adds exactly one
    p_step_r3: assert property (@(posedge clk) disable iff (rst)
        (en && !clr && cnt != ALL_ONES) |=> (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/freq_recip_counter.sv
module freq_recip_counter
    import frq_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk_ref,
    input  logic             rst,
    input  logic             sig_in,
    input  logic             gate_req,
    output logic             busy,
    output logic             done,
    output logic [CNT_W-1:0] sig_count,
    output logic [CNT_W-1:0] ref_count,
    output logic             overflow
);
    // ---------------- reference domain: gate capture ----------------
    logic gate_r, gate_rd;
    always_ff @(posedge clk_ref) begin
        if (rst) begin
            gate_r  <= 1'b0;
            gate_rd <= 1'b0;
        end else begin
            gate_r  <= gate_req;
            gate_rd <= gate_r;
        end
    end
    logic gate_rise;
    assign gate_rise = edge_up(gate_r, gate_rd);

    // ---------------- signal domain: re-timed gate ----------------
    logic en_sig;
    always_ff @(posedge sig_in) begin
        if (rst) en_sig <= 1'b0;
        else     en_sig <= gate_r;
    end
    logic sig_start;
    assign sig_start = gate_r & ~en_sig;

    logic [CNT_W-1:0] sig_cnt;
    logic             sig_ovf;
    frq_sat_counter #(.W(CNT_W)) u_sig_cnt (
        .clk (sig_in),
        .rst (rst),
        .clr (sig_start),
        .en  (en_sig),
        .cnt (sig_cnt),
        .ovf (sig_ovf)
    );

    // ---------------- reference domain: synchronised enable ----------------
    logic en_ref, en_ref_d;
    frq_bit_sync #(.STAGES(SYNC_DEPTH)) u_en_sync (
        .clk (clk_ref),
        .rst (rst),
        .d   (en_sig),
        .q   (en_ref)
    );
    always_ff @(posedge clk_ref) begin
        if (rst) en_ref_d <= 1'b0;
        else     en_ref_d <= en_ref;
    end
    logic en_fall;
    assign en_fall = edge_up(en_ref_d, en_ref);

    logic [CNT_W-1:0] ref_cnt;
    logic             ref_ovf;
    frq_sat_counter #(.W(CNT_W)) u_ref_cnt (
        .clk (clk_ref),
        .rst (rst),
        .clr (gate_rise),
        .en  (en_ref),
        .cnt (ref_cnt),
        .ovf (ref_ovf)
    );

    // ---------------- phase tracking and result capture ----------------
    phase_e phase;
    always_ff @(posedge clk_ref) begin
        if (rst) begin
            phase     <= PH_IDLE;
            done      <= 1'b0;
            sig_count <= '0;
            ref_count <= '0;
            overflow  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (gate_rise) begin
                phase <= PH_MEAS;
            end else if (en_fall) begin
                phase     <= PH_IDLE;
                done      <= 1'b1;
                sig_count <= sig_cnt;
                ref_count <= ref_cnt;
                overflow  <= sig_ovf | ref_ovf;
            end
        end
    end
    assign busy = (phase == PH_MEAS);

    // R2: busy follows the registered gate request on the next edge
    p_busy_set_r2: assert property (@(posedge clk_ref) disable iff (rst)
        gate_rise |=> busy);

    // R2: the synchronised enable is only active inside a measurement
    p_busy_cover_r2: assert property (@(posedge clk_ref) disable iff (rst)
        en_ref |-> busy);

    // R5: done lasts one cycle
    p_done_pulse_r5: assert property (@(posedge clk_ref) disable iff (rst)
        done |=> !done);

    // R5: done marks the end of the measurement
    p_done_idle_r5: assert property (@(posedge clk_ref) disable iff (rst)
        done |-> !busy);

    // R6: published results hold between done pulses
    p_result_hold_r6: assert property (@(posedge clk_ref) disable iff (rst)
        !done |=> ($stable(sig_count) && $stable(ref_count) && $stable(overflow)) || done);
endmodule

// File: tb/test_freq_recip_counter.sv
module test_freq_recip_counter;
    localparam int W      = 10;
    localparam int TOPV   = (1 << W) - 1;
    localparam int NVEC   = 6;
    localparam int VEC_PS [0:NVEC-1] = '{2, 3, 5, 7, 13, 4};
    localparam int VEC_GT [0:NVEC-1] = '{200, 333, 400, 500, 650, 120};

    logic clk_ref = 1'b0;
    logic rst     = 1'b1;
    logic sig_in  = 1'b0;
    logic gate_req = 1'b0;
    logic busy, done, overflow;
    logic [W-1:0] sig_count, ref_count;

    int checks = 0;
    int fails  = 0;
    int sig_half = 10;

    freq_recip_counter #(.CNT_W(W)) i_freq_recip_counter (
        .clk_ref   (clk_ref),
        .rst       (rst),
        .sig_in    (sig_in),
        .gate_req  (gate_req),
        .busy      (busy),
        .done      (done),
        .sig_count (sig_count),
        .ref_count (ref_count),
        .overflow  (overflow)
    );

    // Reference clock: period 10 (100 MHz).
    always #5 clk_ref = ~clk_ref;

    // Measured signal: edges at 3 mod 5, so they never meet a clock edge.
    initial begin
        #3;
        forever begin
            #(sig_half) sig_in = ~sig_in;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Run one gate of gt reference cycles; sample results on the done cycle.
    task automatic measure(input int gt, output bit got);
        got = 1'b0;
        @(negedge clk_ref);
        gate_req = 1'b1;
        @(negedge clk_ref);
        @(negedge clk_ref);
        chk(busy == 1'b1, "R2 busy after gate", busy, 1);
        repeat (gt - 2) @(negedge clk_ref);
        gate_req = 1'b0;
        for (int t = 0; t < 400; t++) begin
            @(negedge clk_ref);
            if (done) begin
                got = 1'b1;
                break;
            end
        end
        chk(got, "R5 done seen", got, 1);
    endtask

    initial begin
        bit got;
        int ps, gt, lo, hi;
        logic [W-1:0] s_hold, r_hold;

        repeat (10) @(negedge clk_ref);
        chk(busy == 0 && done == 0 && overflow == 0, "R1 flags in reset", {busy, done, overflow}, 0);
        rst = 1'b0;
        repeat (3) @(negedge clk_ref);
        chk(sig_count == 0, "R1 sig_count", sig_count, 0);
        chk(ref_count == 0, "R1 ref_count", ref_count, 0);
        chk(busy == 0 && done == 0 && overflow == 0, "R1 flags after reset", {busy, done, overflow}, 0);

        // Vector table.
        for (int v = 0; v < NVEC; v++) begin
            ps = VEC_PS[v];
            gt = VEC_GT[v];
            sig_half = ps * 5;
            repeat (4 * ps) @(negedge clk_ref);
            measure(gt, got);
            if (got) begin
                chk(sig_count > 0 && int'(ref_count) == int'(sig_count) * ps,
                    "R3 whole periods", ref_count, int'(sig_count) * ps);
                lo = gt / ps - 2;
                hi = gt / ps + 2;
                chk(int'(sig_count) >= lo && int'(sig_count) <= hi,
                    "R4 period count", sig_count, gt / ps);
                chk(overflow == 0, "R8 no overflow", overflow, 0);
                chk(busy == 0, "R5 busy low at done", busy, 0);
                s_hold = sig_count;
                r_hold = ref_count;
                @(negedge clk_ref);
                chk(done == 0, "R5 single pulse", done, 0);
                repeat (20) @(negedge clk_ref);
                chk(sig_count == s_hold && ref_count == r_hold, "R6 result held", ref_count, r_hold);
            end
        end

        // R7: reference counter saturates, signal counter does not.
        sig_half = 20;
        repeat (20) @(negedge clk_ref);
        measure(1500, got);
        chk(int'(ref_count) == TOPV, "R7 ref saturates", ref_count, TOPV);
        chk(overflow == 1, "R7 overflow flag ref", overflow, 1);
        chk(int'(sig_count) >= 1500 / 4 - 2 && int'(sig_count) <= 1500 / 4 + 2,
            "R7 sig unaffected", sig_count, 1500 / 4);

        // R8 / R9: next short measurement clears flag and counts.
        sig_half = 25;
        repeat (20) @(negedge clk_ref);
        measure(300, got);
        chk(overflow == 0, "R8 overflow cleared", overflow, 0);
        chk(int'(ref_count) == int'(sig_count) * 5 && int'(sig_count) <= 62,
            "R9 fresh counts", ref_count, int'(sig_count) * 5);

        // R7: signal counter saturates while reference counter also saturates.
        sig_half = 5;
        repeat (20) @(negedge clk_ref);
        measure(2200, got);
        chk(int'(sig_count) == TOPV, "R7 sig saturates", sig_count, TOPV);
        chk(overflow == 1, "R7 overflow flag sig", overflow, 1);

        // R1: reset mid-idle clears outputs.
        rst = 1'b1;
        repeat (4) @(negedge clk_ref);
        chk(sig_count == 0 && ref_count == 0 && overflow == 0, "R1 reset clears", ref_count, 0);
        rst = 1'b0;

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk_ref);
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule